// File: doc/BRIEF.md
# Lane Self-Test Packet Generator

This block drives the transmit side of a built-in self test for a serial lane. Once enabled, it produces an unbroken stream of parallel words with a valid strobe. The words are grouped into packets. Each packet opens with a fixed alignment marker, which a checker at the far end uses to find packet boundaries. Sixteen pseudo-random payload words follow the marker.

The block has two ways to end a run. In counted mode it sends a programmed number of packets and then stops. In free-running mode it keeps sending until software lowers the free-run control. It then finishes the packet in flight and stops. The end of a run raises a completion flag, which stays high until software pulses a separate clear. The clear returns every piece of state to idle, whatever the enable is doing.

A typical test sequence is: set the count and mode, raise enable, wait for completion, then pulse clear and lower enable.

Top module: `lane_bist_gen`

## Requirements
- R1: After reset, `dataValid` and `done` are both 0.
- R2: On the first clock edge where `enable` is 1 while idle and `clearReq` is 0, a run starts. From the next cycle on, `dataValid` is 1 and the words form back-to-back packets of 17 words each. The first word of every packet is the marker 8'hBC.
- R3: Payload words are {1'b0, s}, where s is a 7-bit PRBS state (x^7+x^6+1). The next state is {s[5:0], s[6]^s[5]}. The state is seeded to 7'h7F at the start of every run, and the first payload word of a run carries the seed. The state advances once per payload word and carries on across packet boundaries within a run.
- R4: In counted mode the generator sends exactly `pktCount` packets. The cycle after the last word, `dataValid` is 0 and `done` is 1. A count of 15 gives 255 words.
- R5: A `pktCount` of 0 is treated as 1 packet.
- R6: While `infMode` is 1 at the end of a packet, the run continues whatever the count. Once `infMode` has been seen high during a run and is then 0 at a packet end, the run finishes there. A release partway through a packet therefore completes that packet before `done` rises.
- R7: `done` stays 1 until `clearReq` is raised. While `done` is 1, holding `enable` high starts no new run.
- R8: While `clearReq` is 1, the next cycle shows `dataValid` and `done` at 0. After `clearReq` falls with `enable` still 1, a fresh run starts, reseeded per R3.
- R9: Dropping `enable` during a run makes `dataValid` 0 on the next cycle and leaves `done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Generator enable |
| infMode | input | 1 | Free-running mode control |
| clearReq | input | 1 | Clears internal state to idle |
| pktCount | input | 16 | Packets per counted run (0 means 1) |
| dataOut | output | 8 | Test word |
| dataValid | output | 1 | Word valid strobe |
| done | output | 1 | Sticky run-complete flag |

## Verification
The bench checks that the free-run release completes the packet in flight. It releases once in the middle of a packet and once on a packet's last word. A design that stops at once would truncate the stream, and one that adds an extra packet would overrun it.

A count of zero must give one packet, not 65536. The PRBS state must be reseeded after a clear: a design that kept the old state would produce a second run that differs from the first.

The bench also holds `enable` high after completion. A design whose completion flag was not sticky, or that restarted on its own, would raise `dataValid` again.

// File: rtl/lane_bist_pkg.sv
package lane_bist_pkg;
  // Strobes from the sequencing control to the word datapath
  typedef struct packed {
    logic start;  // reseed PRBS, point at marker slot
    logic step;   // advance one word
  } genStrobe_t;
endpackage

// File: rtl/lane_bist_path.sv
module lane_bist_path
  import lane_bist_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int PAYLOAD_WORDS = 16,
  parameter logic [DATA_W-1:0] MARKER = 8'hBC,
  parameter logic [6:0] SEED  = 7'h7F
) (
  input  logic              clk,
  input  logic              rstN,
  input  genStrobe_t        strb,
  output logic [DATA_W-1:0] dataOut,
  output logic              pktEnd
);
  localparam int IDX_W = $clog2(PAYLOAD_WORDS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAYLOAD_WORDS);

  logic [IDX_W-1:0] wordIdx;
  logic [6:0]       prbs;
  logic [6:0]       prbsNext;

  assign prbsNext = {prbs[5:0], prbs[6] ^ prbs[5]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
      prbs    <= SEED;
    end else if (strb.start) begin
      wordIdx <= '0;
      prbs    <= SEED;
    end else if (strb.step) begin
      wordIdx <= (wordIdx == LAST_IDX) ? '0 : wordIdx + 1'b1;
      if (wordIdx != '0) prbs <= prbsNext;
    end
  end

  assign pktEnd  = (wordIdx == LAST_IDX);
  assign dataOut = (wordIdx == '0) ? MARKER : DATA_W'(prbs);
endmodule

// File: rtl/lane_bist_ctrl.sv
module lane_bist_ctrl
  import lane_bist_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             infMode,
  input  logic             clearReq,
  input  logic [CNT_W-1:0] pktCount,
  input  logic             pktEnd,
  output genStrobe_t       strb,
  output logic             running,
  output logic             finished
);
  typedef enum logic [1:0] {IDLE, RUN, FIN} genState_t;

  genState_t        state;
  logic [CNT_W-1:0] pktSent;
  logic [CNT_W-1:0] target;
  logic             infSeen;
  logic             lastPkt;

  assign lastPkt = infSeen ? 1'b1 : ({1'b0, pktSent} + 1'b1 >= {1'b0, target});

  always_comb begin
    strb.start = (state == IDLE) && enable && !clearReq;
    strb.step  = (state == RUN) && enable && !clearReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      pktSent <= '0;
      target  <= '0;
      infSeen <= 1'b0;
    end else if (clearReq) begin
      state   <= IDLE;
      pktSent <= '0;
      infSeen <= 1'b0;
    end else begin
      unique case (state)
        IDLE: if (enable) begin
          state   <= RUN;
          pktSent <= '0;
          target  <= (pktCount == '0) ? CNT_W'(1) : pktCount;
          infSeen <= infMode;
        end
        RUN: begin
          if (!enable) begin
            state <= IDLE;
          end else begin
            if (infMode) infSeen <= 1'b1;
            if (pktEnd && !infMode) begin
              if (lastPkt) state <= FIN;
              else pktSent <= pktSent + 1'b1;
            end
          end
        end
        default: state <= FIN;
      endcase
    end
  end

  assign running  = (state == RUN);
  assign finished = (state == FIN);
endmodule

// File: rtl/lane_bist_gen.sv
module lane_bist_gen
  import lane_bist_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 16,
  parameter int PAYLOAD_WORDS = 16,
  parameter logic [DATA_W-1:0] MARKER = 8'hBC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              infMode,
  input  logic              clearReq,
  input  logic [CNT_W-1:0]  pktCount,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              done
);
  genStrobe_t strb;
  logic       pktEnd;

  lane_bist_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .infMode(infMode),
    .clearReq(clearReq), .pktCount(pktCount), .pktEnd(pktEnd),
    .strb(strb), .running(dataValid), .finished(done)
  );

  lane_bist_path #(
    .DATA_W(DATA_W), .PAYLOAD_WORDS(PAYLOAD_WORDS), .MARKER(MARKER)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .dataOut(dataOut), .pktEnd(pktEnd)
  );
endmodule

// File: rtl/lane_bist_gen_chk.sv
module lane_bist_gen_chk #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MARKER = 8'hBC
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearReq,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataValid,
  input logic              done
);
  // R2
  first_word_marker_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> dataOut == MARKER);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !clearReq |=> done);

  // R8
  clear_idles_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> !dataValid && !done);

  // R4
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(dataValid));

  // R7
  no_stream_when_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> !done);
endmodule

bind lane_bist_gen lane_bist_gen_chk #(.DATA_W(DATA_W), .MARKER(MARKER)) uChk (
  .clk(clk), .rstN(rstN), .clearReq(clearReq), .dataOut(dataOut),
  .dataValid(dataValid), .done(done)
);

// File: tb/tb_lane_bist_gen.sv
module tb_lane_bist_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        infMode = 1'b0;
  logic        clearReq = 1'b0;
  logic [15:0] pktCount = 16'd0;
  logic [7:0]  dataOut;
  logic        dataValid;
  logic        done;

  int nChecks = 0;
  int nFails  = 0;
  bit ended   = 1'b0;

  localparam int PKT_LEN = 17;

  always #10 clk = ~clk;

  lane_bist_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .infMode(infMode),
    .clearReq(clearReq), .pktCount(pktCount), .dataOut(dataOut),
    .dataValid(dataValid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expects nWords of stream starting at the next negedge; releases infMode at relIdx (-1: never)
  task automatic expectStream(input int nWords, input int relIdx, input string req);
    logic [6:0] s = 7'h7F;
    int bad = 0;
    for (int i = 0; i < nWords; i++) begin
      logic [7:0] exp;
      @(negedge clk);
      exp = (i % PKT_LEN == 0) ? 8'hBC : {1'b0, s};
      if (i % PKT_LEN != 0) s = {s[5:0], s[6] ^ s[5]};
      if (!dataValid || dataOut !== exp) begin
        if (bad == 0) chk(1'b0, $sformatf("%s word %0d", req, i), {dataValid, dataOut}, {1'b1, exp});
        bad++;
      end
      if (i == relIdx) infMode = 1'b0;
    end
    if (bad == 0) chk(1'b1, req, 0, 0);
    @(negedge clk);
    chk(!dataValid && done, {req, " end"}, {dataValid, done}, 2'b01);
  endtask

  task automatic doClear();
    enable = 1'b0;
    clearReq = 1'b1;
    @(negedge clk);
    chk(!dataValid && !done, "R8 clear", {dataValid, done}, 0);
    clearReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    chk(!dataValid && !done, "R1 reset", {dataValid, done}, 0);
  endtask

  task automatic testCounted();
    pktCount = 16'd3; enable = 1'b1;
    expectStream(3 * PKT_LEN, -1, "R2 R3 R4 three packets");
    doClear();
    pktCount = 16'd15; enable = 1'b1;
    expectStream(15 * PKT_LEN, -1, "R4 fifteen packets");
    doClear();
  endtask

  task automatic testZero();
    pktCount = 16'd0; enable = 1'b1;
    expectStream(PKT_LEN, -1, "R5 zero count");
  endtask

  task automatic testSticky();
    repeat (20) @(negedge clk);
    chk(done && !dataValid, "R7 sticky with enable high", {dataValid, done}, 2'b01);
    doClear();
  endtask

  task automatic testInfinite();
    pktCount = 16'd1; infMode = 1'b1; enable = 1'b1;
    expectStream(6 * PKT_LEN, 5 * PKT_LEN + 6, "R6 release mid packet");
    doClear();
    pktCount = 16'd1; infMode = 1'b1; enable = 1'b1;
    expectStream(2 * PKT_LEN, 2 * PKT_LEN - 1, "R6 release on last word");
    doClear();
  endtask

  task automatic testAbort();
    pktCount = 16'd4; enable = 1'b1;
    repeat (10) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!dataValid && !done, "R9 enable drop", {dataValid, done}, 0);
    enable = 1'b1; clearReq = 1'b1;
    @(negedge clk);
    chk(!dataValid && !done, "R8 clear with enable high", {dataValid, done}, 0);
    clearReq = 1'b0;
    expectStream(4 * PKT_LEN, -1, "R8 R3 reseeded run after clear");
    doClear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCounted();
    testZero();
    testSticky();
    testInfinite();
    testAbort();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!ended) begin
      ended = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule